// File: doc/BRIEF.md
# Bit and Status-Flag Instruction Unit

This unit executes the bit-manipulation group of an 8-bit microcontroller instruction set. A 16-bit instruction word arrives with a valid strobe. The unit decodes it and carries it out against its own 8-bit status register and its own file of 32 eight-bit working registers. The group covers four kinds of operation:

- setting or clearing one status flag;
- moving the T flag into one bit of a working register;
- copying one bit of a working register into T;
- setting or clearing one bit of a byte in the low I/O window of data space.

The I/O operations go through a byte-wide data-space bus as a read-modify-write. The bus read data is combinational: it must be valid in the same cycle as the read strobe.

Status-flag and register operations complete in one cycle. An I/O operation occupies a read cycle and then a write cycle. `busy` is high during those two cycles and new instructions are ignored while it is high. `done` pulses one cycle after an instruction completes. Any word outside the group pulses `illegal` instead and changes no state. Two debug ports give a view of the working registers and the status register, for inspection by a surrounding core or a bench.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the status register and all 32 working registers to zero. It also leaves `done`, `illegal`, `bus_rd`, `bus_wr` and `busy` low.
- R2: Status bits are ordered C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The word 1001_0100_Kfff_1000 acts on status bit fff: K=0 sets it and K=1 clears it. The new status value and a `done` pulse are visible in the cycle after the word is accepted.
- R3: A flag set or clear alters only the selected status bit. The other seven bits keep their values.
- R4: Clear-I/O-bit is 1001_1000_pppp_pbbb and set-I/O-bit is 1001_1010_pppp_pbbb. The port p sits in bits 7:3 and the bit index b in bits 2:0. The bus address is p + 0x20, which is always within 0x20..0x3F.
- R5: An I/O bit operation drives `bus_rd` for one cycle, starting the cycle after acceptance. It then drives `bus_wr` in the next cycle. The written byte is the byte read, with bit b cleared or set and all other bits unchanged. `bus_rd` and `bus_wr` are never high together.
- R6: `busy` is high during the read and write cycles. `done` pulses in the cycle after the write. An instruction presented while `busy` is high is ignored.
- R7: Bit-load, 1111_100d_dddd_0bbb, writes the current T flag into bit b of register d (bits 8:4) and leaves the other bits of that register unchanged.
- R8: Bit-store, 1111_101d_dddd_xbbb with bit 3 ignored, copies bit b of register d into T. Register d is not modified.
- R9: Any other word, including 1111_100x_xxxx_1xxx, pulses `illegal` for exactly one cycle after acceptance. It raises no `done` and changes neither the status register nor any working register.
- R10: `dbg_reg_data` shows register `dbg_reg_sel` combinationally, and `dbg_sreg` shows the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| busy | output | 1 | I/O read-modify-write in progress |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| illegal | output | 1 | Unrecognised word (one-cycle pulse) |
| bus_addr | output | 16 | Data-space byte address |
| bus_rd | output | 1 | Data-space read strobe |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_rd` is high |
| bus_wr | output | 1 | Data-space write strobe |
| bus_wdata | output | 8 | Write data |
| dbg_reg_sel | input | 5 | Debug register index |
| dbg_reg_data | output | 8 | Debug register contents |
| dbg_sreg | output | 8 | Status register contents |

## Verification
The checker assumes that `bus_rdata` answers the address in the same cycle as the read strobe. It also assumes that reset is held for several cycles at start-up, so the status register holds a defined value before any cycle-to-cycle comparison is made. The bench meets both assumptions: its data-space model is a combinational byte array that is written on the clock edge, and reset is held for four cycles. Instructions change only on falling edges, and `instr_valid` is normally offered while `busy` is low. The one exception is a deliberate word offered during a read cycle to show that it is dropped.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;
  localparam int PORT_W = 5;

  // status bit positions
  localparam int SR_C = 0;
  localparam int SR_Z = 1;
  localparam int SR_N = 2;
  localparam int SR_V = 3;
  localparam int SR_S = 4;
  localparam int SR_H = 5;
  localparam int SR_T = 6;
  localparam int SR_I = 7;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FLAG  = 3'd1,
    OP_IOCLR = 3'd2,
    OP_IOSET = 3'd3,
    OP_TLOAD = 3'd4,
    OP_TSTOR = 3'd5
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              flag_clr;
    logic [IDX_W-1:0]  bit_idx;
    logic [PORT_W-1:0] port;
    logic [4:0]        reg_idx;
  } dec_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [15:0] word,
  output dec_t        dec
);
  localparam logic [7:0] FLAG_HI  = 8'h94;
  localparam logic [3:0] FLAG_LO  = 4'h8;
  localparam logic [7:0] IOCLR_HI = 8'h98;
  localparam logic [7:0] IOSET_HI = 8'h9A;
  localparam logic [6:0] TLOAD_HI = 7'b1111100;
  localparam logic [6:0] TSTOR_HI = 7'b1111101;

  always_comb begin
    dec          = '0;
    dec.op       = OP_NONE;
    dec.reg_idx  = word[8:4];
    dec.port     = word[7:3];
    dec.flag_clr = word[7];
    if (word[15:8] == FLAG_HI && word[3:0] == FLAG_LO) begin
      dec.op      = OP_FLAG;
      dec.bit_idx = word[6:4];
    end else begin
      dec.bit_idx = word[2:0];
      if (word[15:8] == IOCLR_HI)                       dec.op = OP_IOCLR;
      else if (word[15:8] == IOSET_HI)                  dec.op = OP_IOSET;
      else if (word[15:9] == TLOAD_HI && !word[3])      dec.op = OP_TLOAD;
      else if (word[15:9] == TSTOR_HI)                  dec.op = OP_TSTOR;
    end
  end
endmodule

// File: rtl/bitop_regfile.sv
module bitop_regfile #(
  parameter int NUM_REGS = 32,
  parameter int WIDTH    = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bitop_status.sv
module bitop_status
  import bitop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] sel,
  input  logic             t_wr,
  input  logic             t_val,
  output logic [BYTE_W-1:0] sreg
);
  logic [BYTE_W-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         sreg <= '0;
    else if (set_en) sreg <= sreg | onehot;
    else if (clr_en) sreg <= sreg & ~onehot;
    else if (t_wr)   sreg[SR_T] <= t_val;
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter int          DADDR_W  = 16,
  parameter logic [15:0] IO_BASE  = 16'h0020
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [15:0]        instr,
  output logic               busy,
  output logic               done,
  output logic               illegal,
  output logic [DADDR_W-1:0] bus_addr,
  output logic               bus_rd,
  input  logic [BYTE_W-1:0]  bus_rdata,
  output logic               bus_wr,
  output logic [BYTE_W-1:0]  bus_wdata,
  input  logic [4:0]         dbg_reg_sel,
  output logic [BYTE_W-1:0]  dbg_reg_data,
  output logic [BYTE_W-1:0]  dbg_sreg
);
  localparam int RAW = $clog2(NUM_REGS);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  state_e            state;
  dec_t              dec;
  logic              accept;
  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] reg_rd;
  logic [BYTE_W-1:0] reg_wd;
  logic [BYTE_W-1:0] bit_mask;
  logic [BYTE_W-1:0] io_mask;
  logic [IDX_W-1:0]  io_bit;
  logic              io_set;

  bitop_decode u_dec (.word(instr), .dec(dec));

  assign accept = instr_valid && (state == ST_IDLE);

  always_comb begin
    bit_mask = '0;
    bit_mask[dec.bit_idx] = 1'b1;
    io_mask = '0;
    io_mask[io_bit] = 1'b1;
  end

  assign reg_wd = sreg[SR_T] ? (reg_rd | bit_mask) : (reg_rd & ~bit_mask);

  bitop_regfile #(.NUM_REGS(NUM_REGS), .WIDTH(BYTE_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (accept && dec.op == OP_TLOAD),
    .waddr  (dec.reg_idx[RAW-1:0]),
    .wdata  (reg_wd),
    .raddr_a(dec.reg_idx[RAW-1:0]),
    .rdata_a(reg_rd),
    .raddr_b(dbg_reg_sel[RAW-1:0]),
    .rdata_b(dbg_reg_data)
  );

  bitop_status u_sr (
    .clk   (clk),
    .rst   (rst),
    .set_en(accept && dec.op == OP_FLAG && !dec.flag_clr),
    .clr_en(accept && dec.op == OP_FLAG && dec.flag_clr),
    .sel   (dec.bit_idx),
    .t_wr  (accept && dec.op == OP_TSTOR),
    .t_val (reg_rd[dec.bit_idx]),
    .sreg  (sreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      illegal   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      io_bit    <= '0;
      io_set    <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          unique case (dec.op)
            OP_FLAG, OP_TLOAD, OP_TSTOR: done <= 1'b1;
            OP_IOCLR, OP_IOSET: begin
              bus_rd   <= 1'b1;
              bus_addr <= DADDR_W'(IO_BASE) + DADDR_W'(dec.port);
              io_bit   <= dec.bit_idx;
              io_set   <= (dec.op == OP_IOSET);
              state    <= ST_READ;
            end
            default: illegal <= 1'b1;
          endcase
        end
        ST_READ: begin
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b1;
          bus_wdata <= io_set ? (bus_rdata | io_mask) : (bus_rdata & ~io_mask);
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          bus_wr <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign dbg_sreg = sreg;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int          DADDR_W = 16,
  parameter logic [15:0] IO_BASE = 16'h0020
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               illegal,
  input logic [DADDR_W-1:0] bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [7:0]         dbg_sreg
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (dbg_sreg == 8'h00 && !busy && !bus_rd && !bus_wr && !done));

  // R3
  one_flag_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dbg_sreg ^ $past(dbg_sreg)) <= 1);

  // R4
  io_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> (bus_addr >= DADDR_W'(IO_BASE) && bus_addr <= DADDR_W'(IO_BASE) + DADDR_W'(31)));

  // R5
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R5
  write_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_wr && !bus_rd));

  // R6
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (done && !busy && !bus_wr));

  // R9
  illegal_keeps_sreg_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(dbg_sreg));

  // R9
  illegal_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !done);
endmodule

bind bitop_unit bitop_unit_chk #(.DADDR_W(DADDR_W), .IO_BASE(IO_BASE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .bus_addr(bus_addr),
  .bus_rd  (bus_rd),
  .bus_wr  (bus_wr),
  .dbg_sreg(dbg_sreg)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, illegal, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata, bus_wdata, dbg_reg_data, dbg_sreg;
  logic [4:0]  dbg_reg_sel = '0;

  logic [7:0]  mem [64];
  logic        pre_we = 1'b0;
  logic [5:0]  pre_a = '0;
  logic [7:0]  pre_d = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .busy(busy), .done(done), .illegal(illegal),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data), .dbg_sreg(dbg_sreg)
  );

  assign bus_rdata = mem[bus_addr[5:0]];
  always @(posedge clk) begin
    if (pre_we)      mem[pre_a] <= pre_d;
    else if (bus_wr) mem[bus_addr[5:0]] <= bus_wdata;
  end

  // {instruction, expected status after it}
  localparam logic [23:0] FLAG_VEC [19] = '{
    {16'h9408, 8'h01}, {16'h9418, 8'h03}, {16'h9428, 8'h07}, {16'h9478, 8'h87},
    {16'h9468, 8'hC7}, {16'h9458, 8'hE7}, {16'h9438, 8'hEF}, {16'h9448, 8'hFF},
    {16'h94F8, 8'h7F}, {16'h9488, 8'h7E}, {16'h94D8, 8'h5E}, {16'h94B8, 8'h56},
    {16'h9408, 8'h57}, {16'h94A8, 8'h53}, {16'h9498, 8'h51}, {16'h94C8, 8'h41},
    {16'h94E8, 8'h01}, {16'h9488, 8'h00}, {16'h9488, 8'h00}
  };

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
    instr = '0;
  endtask

  task automatic peek_reg(input logic [4:0] r, output logic [7:0] v);
    dbg_reg_sel = r;
    #1;
    v = dbg_reg_data;
  endtask

  task automatic preload(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_a = a; pre_d = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // one I/O op: checks read cycle, write cycle, done cycle
  task automatic io_op(input string req, input logic [15:0] w,
                       input logic [15:0] exp_addr, input logic [7:0] exp_wd);
    issue(w);
    chk({req, " rd strobe"}, {bus_rd, bus_wr, busy}, 3'b101);
    chk({req, " addr"}, bus_addr, exp_addr);
    @(negedge clk);
    chk({req, " wr strobe"}, {bus_rd, bus_wr, busy}, 3'b011);
    chk({req, " wdata"}, bus_wdata, exp_wd);
    @(negedge clk);
    chk({req, " done"}, {done, busy, bus_wr}, 3'b100);
    chk({req, " mem"}, mem[exp_addr[5:0]], exp_wd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 sreg", dbg_sreg, 8'h00);
    chk("R1 outputs", {done, illegal, bus_rd, bus_wr, busy}, 5'b0);
    peek_reg(5'd17, v);
    chk("R1 reg17", v, 8'h00);

    // R2 R3 flag table
    for (int i = 0; i < 19; i++) begin
      issue(FLAG_VEC[i][23:8]);
      chk("R2/R3 sreg", dbg_sreg, FLAG_VEC[i][7:0]);
      chk("R2 done", done, 1'b1);
    end

    // R4 R5 R6 I/O bit ops
    preload(6'h25, 8'hA5);
    preload(6'h3F, 8'h00);
    preload(6'h20, 8'h04);
    io_op("R4/R5 clr p5 b0", 16'h9828, 16'h0025, 8'hA4);
    io_op("R4/R5 set p31 b7", 16'h9AFF, 16'h003F, 8'h80);
    io_op("R5 set already set", 16'h9A02, 16'h0020, 8'h04);

    // R6 word offered during read cycle is dropped
    issue(16'h9A29);               // set port 5 bit 1
    instr_valid = 1'b1; instr = 16'h9408;  // set C while busy
    @(negedge clk);
    instr_valid = 1'b0; instr = '0;
    chk("R6 wr cycle", {bus_wr, busy}, 2'b11);
    @(negedge clk);
    chk("R6 done", done, 1'b1);
    chk("R6 mem", mem[6'h25], 8'hA6);
    @(negedge clk);
    chk("R6 ignored flag", dbg_sreg, 8'h00);
    chk("R6 no extra done", done, 1'b0);

    // R7 bit-load
    issue(16'h9468);               // T=1
    issue(16'hF835);               // r3 bit5 <- 1
    chk("R7 done", done, 1'b1);
    issue(16'hF9F0);               // r31 bit0 <- 1
    issue(16'hF831);               // r3 bit1 <- 1
    peek_reg(5'd3, v);  chk("R7 r3", v, 8'h22);
    peek_reg(5'd31, v); chk("R7 r31", v, 8'h01);
    issue(16'h94E8);               // T=0
    issue(16'hF835);               // r3 bit5 <- 0
    peek_reg(5'd3, v);  chk("R7 r3 clear", v, 8'h02);
    peek_reg(5'd4, v);  chk("R10 r4 untouched", v, 8'h00);

    // R8 bit-store
    issue(16'hFA39);               // T <- r3[1], bit3 set
    chk("R8 T from r3b1", dbg_sreg, 8'h40);
    peek_reg(5'd3, v);  chk("R8 r3 kept", v, 8'h02);
    issue(16'hFA30);               // T <- r3[0]
    chk("R8 T from r3b0", dbg_sreg, 8'h00);
    issue(16'hFBF0);               // T <- r31[0]
    chk("R8 T from r31b0", dbg_sreg, 8'h40);

    // R9 illegal words
    issue(16'hF838);
    chk("R9 bld bit3", {illegal, done}, 2'b10);
    peek_reg(5'd3, v);  chk("R9 r3 kept", v, 8'h02);
    chk("R9 sreg kept", dbg_sreg, 8'h40);
    @(negedge clk);
    chk("R9 one pulse", illegal, 1'b0);
    issue(16'h0000);
    chk("R9 zero word", {illegal, done, bus_rd}, 3'b100);
    issue(16'h9409);
    chk("R9 near flag", {illegal, done}, 2'b10);
    chk("R9 sreg kept 2", dbg_sreg, 8'h40);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 sreg after reset", dbg_sreg, 8'h00);
    peek_reg(5'd3, v);  chk("R1 r3 after reset", v, 8'h00);
    peek_reg(5'd31, v); chk("R1 r31 after reset", v, 8'h00);

    report();
  end
endmodule